// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Word Controller

This block sits between on-chip logic and a 64-word by 16-bit serial EEPROM that uses a chip-select, clock, data-in and data-out pin set. A user issues a single-word read or write through a request pulse that carries the operation, a 6-bit word address and 16 bits of write data. The controller drives the pins one update at a time, waits a fixed number of clock cycles after each update, and returns an acknowledge pulse. A read acknowledge carries the captured word. A write acknowledge carries an error flag that reports whether the device failed to signal completion in time.

Each write is wrapped in a pair of commands: one that unlocks the device for writing and one that locks it again. Between the phases of a command there is a chip-select toggle pattern that takes the device back to standby. Once a write has been issued, the controller polls data-out until the device reports that it is ready, or until a bounded number of samples has been taken. The time each pin update is held and the spacing between polls are parameters. Real devices need tens of microseconds per step, but a simulation can use a few cycles.

Top module: `mw_eeprom_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, `ee_cs`, `ee_sk`, `ee_di` and `ack` are 0.
- R2: After each change of the pin set {`ee_cs`, `ee_sk`, `ee_di`}, the pins are held for at least HALF_CYCLES clock cycles before the next change. Chip select and serial clock never both change in the same update when chip select rises.
- R3: Command bits are sent most significant bit first. `ee_di` changes only while `ee_sk` is low and stays stable across each high clock phase. `ee_di` returns to 0 after the last bit of a command and remains 0 while read data is being clocked in.
- R4: A read first sets `ee_sk` and `ee_di` low and then raises `ee_cs`. It then sends opcode 3'b110 and the 6-bit address, and clocks in 16 bits MSB first. Each bit is taken from `ee_do` at the end of the high clock phase. On the acknowledge, `rd_data` holds that word and `err` is 0.
- R5: A read ends with a standby pattern (chip select and clock low, clock high, chip select high, clock low). When the read is acknowledged, `ee_cs`=1, `ee_sk`=0 and `ee_di`=0.
- R6: A write sends the following, in this order, and leaves the device locked:
  - the unlock command: opcode 5'b10011 followed by 4 zero bits;
  - a standby pattern;
  - opcode 3'b101, the address and the 16 data bits;
  - a standby pattern, then the completion poll;
  - another standby pattern;
  - the lock command: opcode 5'b10000 followed by 4 zero bits;
  - a cleanup.
- R7: A write ends with a cleanup: chip select and data-in are dropped, then one full clock pulse is given. When the write is acknowledged, `ee_cs`, `ee_sk` and `ee_di` are all 0.
- R8: The completion poll samples `ee_do` every POLL_CYCLES cycles and stops at the first sample that reads 1. In that case `err` is 0 on the acknowledge.
- R9: If POLL_LIMIT samples all read 0, the write still finishes its standby, lock command and cleanup. It is then acknowledged with `err`=1.
- R10: `ack` is a single-cycle pulse and comes exactly once per accepted request.
- R11: `req` is accepted only while the controller is idle. A request raised during a transfer is dropped: it causes no acknowledge and makes no change to the device.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request pulse; sampled only when idle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Word to write |
| ack | output | 1 | One-cycle completion pulse |
| rd_data | output | DATA_W | Word captured by the last read |
| err | output | 1 | Completion timeout of the acknowledged write |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | EEPROM data input (controller to device) |
| ee_do | input | 1 | EEPROM data output (device to controller) |

## Verification
The hardest situation to reach from the ports is a write whose completion poll runs out. To reach it, the device model in the bench must keep data-out low through every poll sample, while the controller still finishes its standby, lock and cleanup steps. The bench has a flag that freezes the model's busy countdown. It performs one write with the flag set and then releases it, so the following read can show that the error flag clears and that the model came back locked. A second hard case is a request that arrives mid-transfer. The bench raises a write request in the middle of a read's shift phase and checks that it produces no acknowledge and no change to the stored word.

// File: rtl/mw_pkg.sv
package mw_pkg;
  timeunit 1ns; timeprecision 1ps;

  localparam logic [2:0] OPC_READ  = 3'b110;
  localparam logic [2:0] OPC_WRITE = 3'b101;
  localparam logic [4:0] OPC_UNLOCK = 5'b10011;
  localparam logic [4:0] OPC_LOCK   = 5'b10000;

  typedef enum logic [4:0] {
    S_IDLE, S_SET0, S_SET1,
    S_OBIT, S_ORISE, S_OFALL, S_OEND,
    S_IRISE, S_IFALL,
    S_SB0, S_SB1, S_SB2, S_SB3,
    S_POLL,
    S_CL0, S_CL1, S_CL2
  } step_t;

  typedef enum logic [2:0] {
    K_SETUP, K_OUT, K_IN, K_STBY, K_POLL, K_CLEAN, K_END
  } seg_t;

  // Segment list of each transfer, indexed by stage number
  function automatic seg_t seg_of(input logic wr, input logic [3:0] st);
    seg_t k;
    k = K_END;
    if (!wr) begin
      case (st)
        4'd0: k = K_SETUP;
        4'd1: k = K_OUT;
        4'd2: k = K_IN;
        4'd3: k = K_STBY;
        default: k = K_END;
      endcase
    end else begin
      case (st)
        4'd0: k = K_SETUP;
        4'd1: k = K_OUT;
        4'd2: k = K_STBY;
        4'd3: k = K_OUT;
        4'd4: k = K_STBY;
        4'd5: k = K_POLL;
        4'd6: k = K_STBY;
        4'd7: k = K_OUT;
        4'd8: k = K_CLEAN;
        default: k = K_END;
      endcase
    end
    return k;
  endfunction
endpackage

// File: rtl/mw_timer.sv
module mw_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] len,
  output logic         done
);
  timeunit 1ns; timeprecision 1ps;

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= len - W'(1);
    else if (cnt != '0)   cnt <= cnt - W'(1);
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/mw_shreg.sv
module mw_shreg #(
  parameter int W = 25
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  input  logic         sin,
  output logic [W-1:0] q
);
  timeunit 1ns; timeprecision 1ps;

  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (load)  q <= load_val;
    else if (shift) q <= {q[W-2:0], sin};
  end
endmodule

// File: rtl/mw_eeprom_ctrl.sv
module mw_eeprom_ctrl
  import mw_pkg::*;
#(
  parameter int HALF_CYCLES = 10000,
  parameter int POLL_CYCLES = 10000,
  parameter int POLL_LIMIT  = 200,
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              req_wr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              ack,
  output logic [DATA_W-1:0] rd_data,
  output logic              err,
  output logic              ee_cs,
  output logic              ee_sk,
  output logic              ee_di,
  input  logic              ee_do
);
  timeunit 1ns; timeprecision 1ps;

  localparam int CMD_W = 3 + ADDR_W;
  localparam int SH_W  = CMD_W + DATA_W;
  localparam int TMAX  = (HALF_CYCLES > POLL_CYCLES) ? HALF_CYCLES : POLL_CYCLES;
  localparam int TW    = $clog2(TMAX + 1);
  localparam int PW    = $clog2(POLL_LIMIT + 1);
  localparam int BW    = $clog2(SH_W + 1);

  step_t             step, nstep;
  logic [3:0]        stage, stage_n;
  logic              op_wr, tout;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [BW-1:0]     bits_left;
  logic [PW-1:0]     poll_cnt;

  logic              tmr_load, tmr_done;
  logic [TW-1:0]     tmr_len;
  logic [SH_W-1:0]   sh_q, ld_val;
  logic [BW-1:0]     ld_len;
  logic              adv, seg_end, start, do_shift, sin, poll_retry, poll_tout;
  logic              sh_load, obit;
  seg_t              seg_n;

  mw_timer #(.W(TW)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .len(tmr_len), .done(tmr_done)
  );

  mw_shreg #(.W(SH_W)) u_shreg (
    .clk(clk), .rst(rst), .load(sh_load), .load_val(ld_val),
    .shift(do_shift), .sin(sin), .q(sh_q)
  );

  assign stage_n = stage + 4'd1;
  assign seg_n   = seg_of(op_wr, stage_n);

  // Command word for the next output segment, left aligned
  always_comb begin
    ld_val = '0;
    ld_len = BW'(CMD_W);
    if (!op_wr) begin
      ld_val = {OPC_READ, addr_q, {DATA_W{1'b0}}};
    end else if (stage_n == 4'd3) begin
      ld_val = {OPC_WRITE, addr_q, wdata_q};
      ld_len = BW'(SH_W);
    end else if (stage_n == 4'd1) begin
      ld_val = {OPC_UNLOCK, {(CMD_W-5){1'b0}}, {DATA_W{1'b0}}};
    end else begin
      ld_val = {OPC_LOCK, {(CMD_W-5){1'b0}}, {DATA_W{1'b0}}};
    end
  end

  always_comb begin
    adv        = tmr_done && (step != S_IDLE) && (step != S_POLL);
    seg_end    = 1'b0;
    start      = 1'b0;
    do_shift   = 1'b0;
    sin        = 1'b0;
    poll_retry = 1'b0;
    poll_tout  = 1'b0;
    nstep      = step;
    case (step)
      S_IDLE:  if (req) begin nstep = S_SET0; start = 1'b1; end
      S_SET0:  if (adv) nstep = S_SET1;
      S_SET1:  if (adv) seg_end = 1'b1;
      S_OBIT:  if (adv) nstep = S_ORISE;
      S_ORISE: if (adv) begin nstep = S_OFALL; do_shift = 1'b1; end
      S_OFALL: if (adv) nstep = (bits_left == '0) ? S_OEND : S_OBIT;
      S_OEND:  if (adv) seg_end = 1'b1;
      S_IRISE: if (adv) begin nstep = S_IFALL; do_shift = 1'b1; sin = ee_do; end
      S_IFALL: if (adv) begin
                 if (bits_left == '0) seg_end = 1'b1;
                 else                 nstep = S_IRISE;
               end
      S_SB0:   if (adv) nstep = S_SB1;
      S_SB1:   if (adv) nstep = S_SB2;
      S_SB2:   if (adv) nstep = S_SB3;
      S_SB3:   if (adv) seg_end = 1'b1;
      S_POLL:  if (tmr_done) begin
                 if (ee_do) seg_end = 1'b1;
                 else if (poll_cnt == PW'(POLL_LIMIT - 1)) begin
                   seg_end = 1'b1; poll_tout = 1'b1;
                 end else poll_retry = 1'b1;
               end
      S_CL0:   if (adv) nstep = S_CL1;
      S_CL1:   if (adv) nstep = S_CL2;
      S_CL2:   if (adv) seg_end = 1'b1;
      default: nstep = S_IDLE;
    endcase
    if (seg_end) begin
      case (seg_n)
        K_OUT:   nstep = S_OBIT;
        K_IN:    nstep = S_IRISE;
        K_STBY:  nstep = S_SB0;
        K_POLL:  nstep = S_POLL;
        K_CLEAN: nstep = S_CL0;
        default: nstep = S_IDLE;
      endcase
    end
    sh_load  = seg_end && (seg_n == K_OUT);
    obit     = sh_load ? ld_val[SH_W-1] : sh_q[SH_W-1];
    tmr_load = start || adv || poll_retry || (step == S_POLL && seg_end);
    if (nstep == S_POLL && step != S_POLL) tmr_len = TW'(1);
    else if (poll_retry)                    tmr_len = TW'(POLL_CYCLES);
    else                                    tmr_len = TW'(HALF_CYCLES);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step      <= S_IDLE;
      stage     <= '0;
      op_wr     <= 1'b0;
      addr_q    <= '0;
      wdata_q   <= '0;
      bits_left <= '0;
      poll_cnt  <= '0;
      tout      <= 1'b0;
      ee_cs     <= 1'b0;
      ee_sk     <= 1'b0;
      ee_di     <= 1'b0;
      ack       <= 1'b0;
      rd_data   <= '0;
      err       <= 1'b0;
    end else begin
      ack  <= 1'b0;
      step <= nstep;
      if (start) begin
        op_wr   <= req_wr;
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
        stage   <= '0;
        tout    <= 1'b0;
      end
      if (do_shift)   bits_left <= bits_left - BW'(1);
      if (poll_retry) poll_cnt  <= poll_cnt + PW'(1);
      if (poll_tout)  tout      <= 1'b1;
      if (seg_end) begin
        stage <= stage_n;
        case (seg_n)
          K_OUT:  bits_left <= ld_len;
          K_IN:   bits_left <= BW'(DATA_W);
          K_POLL: poll_cnt  <= '0;
          K_END: begin
            ack <= 1'b1;
            err <= tout || poll_tout;
            if (!op_wr) rd_data <= sh_q[DATA_W-1:0];
          end
          default: ;
        endcase
      end
      // Pin update on entry to each step
      if (nstep != step) begin
        case (nstep)
          S_SET0:                         begin ee_sk <= 1'b0; ee_di <= 1'b0; end
          S_SET1, S_SB2:                  ee_cs <= 1'b1;
          S_OBIT:                         ee_di <= obit;
          S_ORISE, S_IRISE, S_SB1, S_CL1: ee_sk <= 1'b1;
          S_OFALL, S_IFALL, S_SB3, S_CL2: ee_sk <= 1'b0;
          S_OEND:                         ee_di <= 1'b0;
          S_SB0:                          begin ee_cs <= 1'b0; ee_sk <= 1'b0; end
          S_CL0:                          begin ee_cs <= 1'b0; ee_di <= 1'b0; end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/mw_eeprom_chk.sv
module mw_eeprom_chk #(
  parameter int HALF_CYCLES = 2
) (
  input logic clk,
  input logic rst,
  input logic ee_cs,
  input logic ee_sk,
  input logic ee_di,
  input logic ack
);
  timeunit 1ns; timeprecision 1ps;

  localparam int GW = $clog2(HALF_CYCLES + 1) + 1;

  logic [2:0]    pins_q;
  logic [GW-1:0] gap;
  logic          chg;

  assign chg = ({ee_cs, ee_sk, ee_di} != pins_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      pins_q <= '0;
      gap    <= GW'(HALF_CYCLES);
    end else begin
      pins_q <= {ee_cs, ee_sk, ee_di};
      if (chg)                          gap <= GW'(1);
      else if (gap < GW'(HALF_CYCLES))  gap <= gap + GW'(1);
    end
  end

  a_r2_pin_hold: assert property (@(posedge clk) disable iff (rst)
    chg |-> (gap >= GW'(HALF_CYCLES)));

  a_r2_cs_rise_alone: assert property (@(posedge clk) disable iff (rst)
    $rose(ee_cs) |-> $stable(ee_sk));

  a_r3_di_hold_high: assert property (@(posedge clk) disable iff (rst)
    (ee_sk && $past(ee_sk)) |-> $stable(ee_di));

  a_r3_di_at_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(ee_sk) |-> $stable(ee_di));

  a_r10_ack_pulse: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack);
endmodule

bind mw_eeprom_ctrl mw_eeprom_chk #(.HALF_CYCLES(HALF_CYCLES)) u_chk (
  .clk(clk), .rst(rst), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ack(ack)
);

// File: tb/mw_eeprom_ctrl_test.sv
module mw_eeprom_ctrl_test;
  timeunit 1ns; timeprecision 1ps;

  localparam int HALF = 2;
  localparam int PCYC = 3;
  localparam int PLIM = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req = 1'b0, req_wr = 1'b0;
  logic [5:0]  req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic ack, err, ee_cs, ee_sk, ee_di;
  logic [15:0] rd_data;
  logic ee_do;

  always #2.5 clk = ~clk;   // 200 MHz

  mw_eeprom_ctrl #(.HALF_CYCLES(HALF), .POLL_CYCLES(PCYC), .POLL_LIMIT(PLIM)) uut (
    .clk(clk), .rst(rst), .req(req), .req_wr(req_wr), .req_addr(req_addr),
    .req_wdata(req_wdata), .ack(ack), .rd_data(rd_data), .err(err),
    .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do)
  );

  int nchk = 0, nfail = 0;
  bit finished = 0;

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // ---------------- device model ----------------
  logic [15:0] mem [64];
  logic [15:0] exp_mem [64];
  logic        cs_q = 0, sk_q = 0, di_q = 0;
  logic [24:0] sreg = '0, sh_n;
  logic [4:0]  nbits = '0, rcnt = '0;
  logic        reading = 0, wen = 0, pend = 0, stuck = 0, dout = 1;
  logic [5:0]  raddr = '0;
  int          busy = 0, busy_len = 8, proto = 0, di_in_err = 0;
  assign ee_do = dout;

  initial for (int i = 0; i < 64; i++) begin
    mem[i]     = 16'hA5C3 ^ 16'(i * 16'h0111);
    exp_mem[i] = 16'hA5C3 ^ 16'(i * 16'h0111);
  end

  always @(posedge clk) begin
    cs_q <= ee_cs; sk_q <= ee_sk; di_q <= ee_di;
    if (!rst && ee_sk && sk_q && ee_di != di_q) proto <= proto + 1;
    if (!ee_cs) begin
      nbits <= '0; reading <= 0;
    end else if (!cs_q) begin
      nbits <= '0;
      if (pend) begin busy <= busy_len; dout <= 1'b0; pend <= 0; end
    end else if (ee_sk && !sk_q) begin
      if (reading) begin
        if (rcnt < 5'd16) begin
          dout <= mem[raddr][4'd15 - rcnt[3:0]];
          rcnt <= rcnt + 5'd1;
          if (ee_di) di_in_err <= di_in_err + 1;
        end
      end else begin
        sh_n = {sreg[23:0], ee_di};
        sreg  <= sh_n;
        nbits <= nbits + 5'd1;
        if (nbits == 5'd8) begin
          if (sh_n[8:6] == 3'b110) begin reading <= 1; raddr <= sh_n[5:0]; rcnt <= '0; end
          else if (sh_n[8:4] == 5'b10011) wen <= 1;
          else if (sh_n[8:4] == 5'b10000) wen <= 0;
        end
        if (nbits == 5'd24 && sh_n[24:22] == 3'b101) begin
          if (wen) mem[sh_n[21:16]] <= sh_n[15:0];
          pend <= 1;
        end
      end
    end
    if (busy != 0 && !stuck && !(ee_cs && !cs_q)) begin
      busy <= busy - 1;
      if (busy == 1) dout <= 1'b1;
    end
  end

  // pin spacing measurement (R2)
  int cyc = 0, last_chg = -1, min_gap = 1000000;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst && {ee_cs, ee_sk, ee_di} != {cs_q, sk_q, di_q}) begin
      if (last_chg >= 0 && (cyc - last_chg) < min_gap) min_gap = cyc - last_chg;
      last_chg = cyc;
    end
  end

  // ---------------- scoreboard ----------------
  typedef struct { bit wr; logic [5:0] addr; logic [15:0] data; bit err; } exp_t;
  exp_t sbq[$];
  int ack_cnt = 0;

  always @(negedge clk) begin
    if (!rst && ack) begin
      ack_cnt++;
      if (sbq.size() == 0) begin
        check(0, "R10/R11 unexpected ack", 1, 0);
      end else begin
        exp_t it;
        it = sbq.pop_front();
        check(err == it.err, it.err ? "R9 timeout flag" : "R8 err clear", 32'(err), 32'(it.err));
        if (!it.wr) begin
          check(rd_data == it.data, "R4 read data", 32'(rd_data), 32'(it.data));
          check({ee_cs, ee_sk, ee_di} == 3'b100, "R5 standby at read end",
                32'({ee_cs, ee_sk, ee_di}), 32'h4);
        end else begin
          check({ee_cs, ee_sk, ee_di} == 3'b000, "R7 cleanup at write end",
                32'({ee_cs, ee_sk, ee_di}), 32'h0);
          check(mem[it.addr] == it.data, "R6 word stored", 32'(mem[it.addr]), 32'(it.data));
          check(wen == 1'b0, "R6 device locked after write", 32'(wen), 32'h0);
        end
      end
    end
  end

  task automatic run_op(bit wr, logic [5:0] a, logic [15:0] d, bit e);
    exp_t it;
    int tgt;
    it.wr = wr; it.addr = a; it.err = e;
    it.data = wr ? d : exp_mem[a];
    sbq.push_back(it);
    if (wr) exp_mem[a] = d;
    tgt = ack_cnt + 1;
    @(negedge clk);
    req = 1; req_wr = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req = 0;
    wait (ack_cnt >= tgt);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog: actual %0d expected 0", 1);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    check({ee_cs, ee_sk, ee_di, ack} == 4'b0, "R1 reset pins",
          32'({ee_cs, ee_sk, ee_di, ack}), 32'h0);
    rst = 0;
    @(negedge clk);
    check({ee_cs, ee_sk, ee_di, ack} == 4'b0, "R1 after reset",
          32'({ee_cs, ee_sk, ee_di, ack}), 32'h0);

    // R4 reads of untouched words, both address ends
    run_op(0, 6'd21, '0, 0);
    run_op(0, 6'd0,  '0, 0);
    run_op(0, 6'd63, '0, 0);
    // R6/R8 writes then read back
    run_op(1, 6'd5,  16'h1234, 0);
    run_op(0, 6'd5,  '0, 0);
    run_op(1, 6'd63, 16'hFFFF, 0);
    run_op(0, 6'd63, '0, 0);
    run_op(1, 6'd0,  16'h0000, 0);
    run_op(0, 6'd0,  '0, 0);
    // R8 slower device, still within the poll window
    busy_len = 12;
    run_op(1, 6'd33, 16'h5A0F, 0);
    busy_len = 8;
    // R9 device never ready
    stuck = 1;
    run_op(1, 6'd10, 16'hBEEF, 1);
    stuck = 0;
    repeat (20) @(negedge clk);
    run_op(0, 6'd10, '0, 0);

    // R11 request during a transfer is dropped
    begin
      exp_t it;
      int base;
      it.wr = 0; it.addr = 6'd42; it.err = 0; it.data = exp_mem[42];
      sbq.push_back(it);
      base = ack_cnt;
      @(negedge clk); req = 1; req_wr = 0; req_addr = 6'd42;
      @(negedge clk); req = 0;
      repeat (30) @(negedge clk);
      req = 1; req_wr = 1; req_addr = 6'd7; req_wdata = 16'hDEAD;
      @(negedge clk); req = 0;
      wait (ack_cnt >= base + 1);
      repeat (600) @(negedge clk);
      check(ack_cnt == base + 1, "R11 no extra ack", 32'(ack_cnt - base), 32'h1);
      check(mem[7] == exp_mem[7], "R11 word untouched", 32'(mem[7]), 32'(exp_mem[7]));
    end

    check(min_gap >= HALF, "R2 pin hold", 32'(min_gap), 32'(HALF));
    check(proto == 0, "R3 di stable in high phase", 32'(proto), 32'h0);
    check(di_in_err == 0, "R3 di low during data in", 32'(di_in_err), 32'h0);
    check(sbq.size() == 0, "R10 one ack per request", 32'(sbq.size()), 32'h0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule